// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures a slow, imprecise clock against a fast, accurate reference clock. It runs entirely in the reference domain. One of three slow clock inputs is chosen, brought across with a two-flop synchroniser and reduced to a one-cycle rising-edge pulse. The block then counts reference cycles across a programmed number of slow periods. Software divides the result by the period count to get the ratio between the two clocks. That arithmetic, and switching the oscillators on, are outside the block.

A measurement can run once or repeat without a gap. In single mode a rising edge on the start input arms the counter. The counter waits for a slow edge, counts until the programmed number of slow edges has passed, publishes the count and raises the ready flag. In repeat mode, the edge that ends one measurement also opens the next one, and the result is refreshed after every run. The repeat enable is meant to be held high from reset. A limit of zero skips counting: ready rises at the next slow edge, so the block doubles as a "wait one slow cycle" primitive. The result counter saturates, and a sticky flag records that it did.

Top module: `slow_cal_counter`

## Requirements
- R1: The result equals the number of reference cycles between the slow edge that starts a measurement and the slow edge that completes the programmed number of slow periods (limit L with slow period P gives L*P).
- R2: In single mode one measurement runs, ready goes high and stays high, and the result stays fixed until another measurement is launched.
- R3: While `cont_en_i` is high (including straight after reset), measurements repeat back to back. The closing slow edge of one run is the opening edge of the next, and the result is refreshed after each run.
- R4: `start_i` acts only on a low-to-high transition. Holding it high launches nothing further; taking it low and then high again launches a new measurement.
- R5: Launching a measurement from idle clears `ready_o` on the next reference cycle, before the measurement can complete.
- R6: With a limit of zero, ready rises at the first synchronised slow edge after launch and the result is 0.
- R7: The limit saturates one below all-ones: an all-ones limit (32767 at the default 15-bit width) behaves as all-ones minus one (32766).
- R8: `src_sel_i` picks the slow source: 0 the internal ~150 kHz oscillator, 1 the 32.768 kHz crystal, 2 the fast RC oscillator divided by 256 (bits 0, 1, 2 of `slow_clk_i`). Code 3 falls back to source 0.
- R9: The result counter saturates at all-ones instead of wrapping. `ovf_o` becomes 1 when the count would pass all-ones, stays 1, and clears only when a new measurement is launched from idle.
- R10: With both `start_i` and `cont_en_i` low, a measurement in progress is abandoned. The block returns to idle, `ready_o` and the result keep their values, and nothing more is published.
- R11: After reset, `ready_o`, `value_o` and `ovf_o` are all 0.
- R12: A slow edge is seen by the control logic three reference cycles after the edge at which it is first sampled (two synchroniser flops plus an edge-detect flop).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_clk_i | input | SRC_N | Slow clock sources, asynchronous to `clk_ref` |
| src_sel_i | input | SEL_W | Slow source select |
| cycle_lim_i | input | LIM_W | Number of slow periods to measure |
| start_i | input | 1 | Single-measurement launch, rising-edge sensitive |
| cont_en_i | input | 1 | Repeat-mode enable |
| ready_o | output | 1 | Result valid flag |
| value_o | output | VAL_W | Reference cycles counted |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
Each slow source toggles with its own fixed period in reference cycles, so every expected count is an exact product. The three sources, plus the fallback code, give three different products; a wrong select or a misrouted fallback shows up as a wrong multiple. Limits 0, small values, all-ones and a value large enough to pass the counter's range are run separately. These separate the wait-one-edge case, plain counting, the limit clamp and saturation with its sticky flag. Held starts, re-armed starts, repeat runs with a changed limit, and an abort in the middle of a run separate edge-triggered launch, back-to-back chaining and abandonment. A cycle-level model checks the latency of every ready transition.

// File: rtl/slow_cal_pkg.sv
package slow_cal_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_ARM  = 2'd1,
    CAL_MEAS = 2'd2
  } cal_state_e;
endpackage

// File: rtl/slow_src_sync.sv
module slow_src_sync #(
  parameter int SRC_N = 3,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             rise_o
);
  localparam int STAGES = 3;

  logic              picked;
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  // source mux; codes beyond SRC_N-1 fall back to source 0
  always_comb begin
    picked = src_i[0];
    for (int i = 1; i < SRC_N; i++) begin
      if (sel_i == SEL_W'(i)) picked = src_i[i];
    end
  end

  // two synchroniser stages followed by one history stage
  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], picked};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] next_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign at_max_o = (cnt_q == MAXV);
  assign next_o   = at_max_o ? MAXV : cnt_q + W'(1);
  assign cnt_en   = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = next_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import slow_cal_pkg::*;
#(
  parameter int LIM_W = 15,
  parameter int VAL_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cont_en_i,
  input  logic [LIM_W-1:0] limit_i,
  input  logic             slow_rise_i,
  input  logic [VAL_W-1:0] ref_next_i,
  input  logic             ref_at_max_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             ready_o,
  output logic [VAL_W-1:0] value_o,
  output logic             ovf_o,
  output cal_state_e       state_o,
  output logic             start_pulse_o,
  output logic [LIM_W-1:0] eff_lim_o
);
  localparam logic [LIM_W-1:0] LIM_ONES = '1;
  localparam logic [LIM_W-1:0] LIM_TOP  = LIM_ONES - LIM_W'(1);

  cal_state_e       st_q, st_d;
  logic [LIM_W-1:0] sc_q, sc_d;
  logic             ready_q, ready_d;
  logic [VAL_W-1:0] value_q, value_d;
  logic             ovf_q, ovf_d;
  logic             start_q;
  logic             abort;
  logic             last_edge;
  logic [LIM_W:0]   sc_inc;
  logic [LIM_W-1:0] eff_lim;

  assign eff_lim       = (limit_i == LIM_ONES) ? LIM_TOP : limit_i;
  assign start_pulse_o = start_i & ~start_q;
  assign abort         = ~start_i & ~cont_en_i;
  assign sc_inc        = {1'b0, sc_q} + (LIM_W+1)'(1);
  assign last_edge     = slow_rise_i & (sc_inc >= {1'b0, eff_lim});

  always_comb begin
    st_d      = st_q;
    sc_d      = sc_q;
    ready_d   = ready_q;
    value_d   = value_q;
    ovf_d     = ovf_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    unique case (st_q)
      CAL_IDLE: begin
        if (start_pulse_o || cont_en_i) begin
          st_d    = CAL_ARM;
          ready_d = 1'b0;
          ovf_d   = 1'b0;
        end
      end
      CAL_ARM: begin
        if (abort) begin
          st_d = CAL_IDLE;
        end else if (slow_rise_i) begin
          if (eff_lim == '0) begin
            ready_d = 1'b1;
            value_d = '0;
            if (!cont_en_i) st_d = CAL_IDLE;
          end else begin
            st_d      = CAL_MEAS;
            cnt_clr_o = 1'b1;
            sc_d      = '0;
          end
        end
      end
      CAL_MEAS: begin
        if (abort) begin
          st_d = CAL_IDLE;
        end else if (last_edge) begin
          value_d = ref_next_i;
          ready_d = 1'b1;
          if (ref_at_max_i) ovf_d = 1'b1;
          if (cont_en_i) begin
            cnt_clr_o = 1'b1;
            sc_d      = '0;
          end else begin
            st_d = CAL_IDLE;
          end
        end else begin
          cnt_inc_o = 1'b1;
          if (ref_at_max_i) ovf_d = 1'b1;
          if (slow_rise_i)  sc_d  = sc_inc[LIM_W-1:0];
        end
      end
      default: st_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CAL_IDLE;
      sc_q    <= '0;
      ready_q <= 1'b0;
      value_q <= '0;
      ovf_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sc_q    <= sc_d;
      ready_q <= ready_d;
      value_q <= value_d;
      ovf_q   <= ovf_d;
      start_q <= start_i;
    end
  end

  assign ready_o   = ready_q;
  assign value_o   = value_q;
  assign ovf_o     = ovf_q;
  assign state_o   = st_q;
  assign eff_lim_o = eff_lim;
endmodule

// File: rtl/slow_cal_counter.sv
module slow_cal_counter
  import slow_cal_pkg::*;
#(
  parameter int SRC_N = 3,
  parameter int SEL_W = 2,
  parameter int LIM_W = 15,
  parameter int VAL_W = 20
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] slow_clk_i,
  input  logic [SEL_W-1:0] src_sel_i,
  input  logic [LIM_W-1:0] cycle_lim_i,
  input  logic             start_i,
  input  logic             cont_en_i,
  output logic             ready_o,
  output logic [VAL_W-1:0] value_o,
  output logic             ovf_o
);
  logic             rst_meta_n, rst_sync_n;
  logic             slow_rise;
  logic             cnt_clr, cnt_inc, cnt_at_max;
  logic [VAL_W-1:0] ref_cnt, ref_next;
  cal_state_e       state;
  logic             start_pulse;
  logic [LIM_W-1:0] eff_lim;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  slow_src_sync #(.SRC_N(SRC_N), .SEL_W(SEL_W)) u_sync (
    .clk    (clk_ref),
    .rst_n  (rst_sync_n),
    .src_i  (slow_clk_i),
    .sel_i  (src_sel_i),
    .rise_o (slow_rise)
  );

  sat_counter #(.W(VAL_W)) u_cnt (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .clr_i    (cnt_clr),
    .inc_i    (cnt_inc),
    .cnt_o    (ref_cnt),
    .next_o   (ref_next),
    .at_max_o (cnt_at_max)
  );

  cal_ctrl #(.LIM_W(LIM_W), .VAL_W(VAL_W)) u_ctrl (
    .clk           (clk_ref),
    .rst_n         (rst_sync_n),
    .start_i       (start_i),
    .cont_en_i     (cont_en_i),
    .limit_i       (cycle_lim_i),
    .slow_rise_i   (slow_rise),
    .ref_next_i    (ref_next),
    .ref_at_max_i  (cnt_at_max),
    .cnt_clr_o     (cnt_clr),
    .cnt_inc_o     (cnt_inc),
    .ready_o       (ready_o),
    .value_o       (value_o),
    .ovf_o         (ovf_o),
    .state_o       (state),
    .start_pulse_o (start_pulse),
    .eff_lim_o     (eff_lim)
  );
endmodule

// File: rtl/slow_cal_chk.sv
module slow_cal_chk
  import slow_cal_pkg::*;
#(
  parameter int LIM_W = 15,
  parameter int VAL_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cont_en_i,
  input logic             ready_o,
  input logic [VAL_W-1:0] value_o,
  input logic             ovf_o,
  input cal_state_e       state,
  input logic             slow_rise,
  input logic             start_pulse,
  input logic [LIM_W-1:0] eff_lim,
  input logic [VAL_W-1:0] ref_cnt
);
  localparam logic [VAL_W-1:0] VMAX = '1;

  // R5
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAL_IDLE && (start_pulse || cont_en_i)) |=> !ready_o);

  // R6
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CAL_ARM && slow_rise && eff_lim == '0 && (start_i || cont_en_i))
      |=> (ready_o && value_o == '0));

  // R9
  sat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(ref_cnt) == VMAX));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != CAL_IDLE && !start_i && !cont_en_i) |=> (state == CAL_IDLE));

  // R2
  value_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value_o) |-> ready_o);

  // R12
  ready_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(slow_rise));
endmodule

bind slow_cal_counter slow_cal_chk #(.LIM_W(LIM_W), .VAL_W(VAL_W)) u_chk (
  .clk         (clk_ref),
  .rst_n       (rst_sync_n),
  .start_i     (start_i),
  .cont_en_i   (cont_en_i),
  .ready_o     (ready_o),
  .value_o     (value_o),
  .ovf_o       (ovf_o),
  .state       (state),
  .slow_rise   (slow_rise),
  .start_pulse (start_pulse),
  .eff_lim     (eff_lim),
  .ref_cnt     (ref_cnt)
);

// File: tb/test_slow_cal_counter.sv
module test_slow_cal_counter;
  localparam int LIM_W = 8;
  localparam int VAL_W = 13;
  localparam int VMAX  = (1 << VAL_W) - 1;
  localparam int LONES = (1 << LIM_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       slow = 3'b000;
  logic [1:0]       sel = 2'd0;
  logic [LIM_W-1:0] lim = 8'd4;
  logic             start = 1'b0;
  logic             cont = 1'b0;
  logic             ready;
  logic [VAL_W-1:0] value;
  logic             ovf;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string cur_req = "R11";
  int half [3] = '{10, 40, 13};
  int tick [3] = '{0, 0, 0};

  always #2 clk = ~clk;

  slow_cal_counter #(.SRC_N(3), .SEL_W(2), .LIM_W(LIM_W), .VAL_W(VAL_W)) i_slow_cal_counter (
    .clk_ref     (clk),
    .rst_n       (rst_n),
    .slow_clk_i  (slow),
    .src_sel_i   (sel),
    .cycle_lim_i (lim),
    .start_i     (start),
    .cont_en_i   (cont),
    .ready_o     (ready),
    .value_o     (value),
    .ovf_o       (ovf)
  );

  // slow sources: fixed half periods in reference cycles
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (tick[i] == half[i] - 1) begin
        tick[i] = 0;
        slow[i] = ~slow[i];
      end else begin
        tick[i] = tick[i] + 1;
      end
    end
  end

  // behavioural reference model
  bit samp[$];
  int m_st, m_cnt, m_sc, m_value;
  bit m_ready, m_ovf, m_prev_start;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp = {};
      for (int k = 0; k < 3; k++) samp.push_back(1'b0);
      m_st = 0; m_cnt = 0; m_sc = 0; m_value = 0;
      m_ready = 0; m_ovf = 0; m_prev_start = 0;
    end else begin
      bit rise, pulse, abrt;
      int el;
      rise  = samp[$-1] && !samp[$-2];
      pulse = start && !m_prev_start;
      abrt  = !start && !cont;
      el    = (int'(lim) == LONES) ? LONES - 1 : int'(lim);
      case (m_st)
        0: if (pulse || cont) begin m_st = 1; m_ready = 0; m_ovf = 0; end
        1: begin
          if (abrt) m_st = 0;
          else if (rise) begin
            if (el == 0) begin
              m_ready = 1; m_value = 0;
              if (!cont) m_st = 0;
            end else begin
              m_st = 2; m_cnt = 0; m_sc = 0;
            end
          end
        end
        default: begin
          if (abrt) m_st = 0;
          else if (rise && m_sc + 1 >= el) begin
            m_value = (m_cnt + 1 > VMAX) ? VMAX : m_cnt + 1;
            if (m_cnt + 1 > VMAX) m_ovf = 1;
            m_ready = 1;
            if (cont) begin m_cnt = 0; m_sc = 0; end
            else m_st = 0;
          end else begin
            if (m_cnt + 1 > VMAX) m_ovf = 1;
            else m_cnt = m_cnt + 1;
            if (rise) m_sc = m_sc + 1;
          end
        end
      endcase
      m_prev_start = start;
      samp.push_back(sel == 2'd1 ? slow[1] : (sel == 2'd2 ? slow[2] : slow[0]));
      void'(samp.pop_front());
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (ready !== m_ready || int'(value) != m_value || ovf !== m_ovf) begin
        n_fail++;
        $display("FAIL %s cycle %0d: ready/value/ovf actual %0b/%0d/%0b expected %0b/%0d/%0b",
                 cur_req, cyc, ready, value, ovf, m_ready, m_value, m_ovf);
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      report();
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready(string req);
    int n = 0;
    while (!ready && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(ready), 1);
  endtask

  task automatic one_shot(string req, logic [1:0] s, logic [LIM_W-1:0] l);
    cur_req = req;
    @(negedge clk); sel = s; lim = l; start = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk);
    chk("R5 ready cleared at launch", int'(ready), 0);
    wait_ready(req);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R11 ready", int'(ready), 0);
    chk("R11 value", int'(value), 0);
    chk("R11 ovf", int'(ovf), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // R1: source 0 period 20, limit 4
    one_shot("R1", 2'd0, 8'd4);
    chk("R1 value", int'(value), 80);
    // R2/R4: start held high, nothing further happens
    cur_req = "R2";
    repeat (300) @(negedge clk);
    chk("R2 ready held", int'(ready), 1);
    chk("R4 held start relaunches nothing", int'(value), 80);

    // R8: source select, including fallback code
    one_shot("R8", 2'd1, 8'd3);
    chk("R8 source 1", int'(value), 240);
    one_shot("R8", 2'd2, 8'd5);
    chk("R8 source 2", int'(value), 130);
    one_shot("R8", 2'd3, 8'd4);
    chk("R8 code 3 falls back", int'(value), 80);

    // R6: zero limit waits one slow edge
    one_shot("R6", 2'd0, 8'd0);
    chk("R6 value", int'(value), 0);

    // R7: all-ones limit clamps
    one_shot("R7", 2'd0, 8'd255);
    chk("R7 clamped limit", int'(value), 254 * 20);

    // R9: saturation and sticky flag
    one_shot("R9", 2'd1, 8'd200);
    chk("R9 saturated value", int'(value), VMAX);
    chk("R9 ovf set", int'(ovf), 1);
    repeat (200) @(negedge clk);
    chk("R9 ovf sticky", int'(ovf), 1);
    one_shot("R9", 2'd0, 8'd2);
    chk("R9 ovf cleared by launch", int'(ovf), 0);
    chk("R9 next value", int'(value), 40);

    // R10: abort mid measurement
    cur_req = "R10";
    @(negedge clk); start = 1'b0; lim = 8'd50;
    @(negedge clk); start = 1'b1;
    repeat (100) @(negedge clk);
    start = 1'b0;
    repeat (1500) @(negedge clk);
    chk("R10 ready after abort", int'(ready), 0);
    chk("R10 value after abort", int'(value), 40);

    // R3: repeat mode, back to back
    cur_req = "R3";
    @(negedge clk); sel = 2'd2; lim = 8'd3; cont = 1'b1;
    wait_ready("R3");
    chk("R3 first run", int'(value), 78);
    @(negedge clk); lim = 8'd2;
    repeat (300) @(negedge clk);
    chk("R3 refreshed run", int'(value), 52);
    chk("R3 ready", int'(ready), 1);
    cont = 1'b0;
    repeat (50) @(negedge clk);
    chk("R10 repeat stopped", int'(value), 52);

    report();
  end
endmodule